// File: doc/BRIEF.md
# Limb Right Shifter with Carry Word

This block shifts one 64-bit limb of a multi-limb integer right by 0 to 63 bit positions. It has three inputs: the limb's data word, a carry-in word, and a shift-amount word. It has two outputs: a result word and a carry-out word.

The carry-in holds, in its top bits, the bits that the next more-significant limb shifted out. The carry-out holds this limb's own shifted-out bits, placed at the top of the word, ready for the next less-significant limb. If the limbs are processed from the most significant limb downward, and each carry-out feeds the next carry-in, the whole number is shifted right by the same count.

The datapath uses a single W-bit rotator and one mask. It has no double-width funnel shifter. A parameter can add one output register stage for timing.

Top module: `limb_rshift_carry`

## Requirements
- R1: The shift count n is taken from bits [5:0] of `amount` (log2 W bits in general). Bits 6 and above have no effect on either output.
- R2: Bits [W-1-n:0] of `result` equal `data_in` shifted right by n.
- R3: For n > 0, the top n bits of `result` (bits [W-1:W-n]) equal the same bit positions of `carry_in`.
- R4: For n > 0, bits [W-1:W-n] of `carry_out` hold bits [n-1:0] of `data_in`, in order, and all lower bits of `carry_out` are zero.
- R5: When n = 0, `result` equals `data_in` and `carry_out` is zero, whatever the value of `carry_in`.
- R6: Limbs are processed from the most significant downward, each limb's `carry_out` feeds the next limb's `carry_in`, and the top limb gets a zero carry-in. The resulting limbs then equal the whole multi-limb number shifted right by n.
- R7: With OUT_REG = 1, both outputs show the values for the inputs sampled at the previous rising clock edge. Both outputs are zero while `rst_n` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output stage and for the checks |
| rst_n | input | 1 | Active-low asynchronous reset of the optional output stage |
| data_in | input | W | Limb to be shifted |
| carry_in | input | W | Bits moved down from the more-significant limb, held at the top of the word |
| amount | input | W | Shift-amount word; only the low log2(W) bits are used |
| result | output | W | Shifted limb |
| carry_out | output | W | Bits shifted out of this limb, placed at the top of the word |

## Verification
The bench builds two copies at W = 64: one purely combinational (OUT_REG = 0) and one with the output register (OUT_REG = 1). Every shift count from 0 to 63 is applied to both, with several data and carry-in patterns per count, and with random upper bits in the amount word. This covers the zero-shift case, the maximum shift, and the claim that the high amount bits are ignored. A four-limb chain through the combinational copy is compared against a 256-bit shift for a range of counts, which checks how the carry word hands bits from one limb to the next.

// File: rtl/limb_rshift_carry.sv
module limb_rshift_carry #(
  parameter int W       = 64,
  parameter bit OUT_REG = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] data_in,
  input  logic [W-1:0] carry_in,
  input  logic [W-1:0] amount,
  output logic [W-1:0] result,
  output logic [W-1:0] carry_out
);
  localparam int SW = $clog2(W);
  localparam logic [SW:0] WIDE_W = SW'(0) + (SW+1)'(W);

  logic [SW-1:0] n;
  logic [SW:0]   back;
  logic [W-1:0]  rot, keep, res_c, cry_c;

  assign n     = amount[SW-1:0];
  assign back  = WIDE_W - {1'b0, n};
  assign rot   = (data_in >> n) | (data_in << back);
  assign keep  = {W{1'b1}} >> n;
  assign res_c = (rot & keep) | (carry_in & ~keep);
  assign cry_c = rot & ~keep;

  generate
    if (OUT_REG) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          result    <= '0;
          carry_out <= '0;
        end else begin
          result    <= res_c;
          carry_out <= cry_c;
        end
      end

      assert_pipe_delay_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (result == $past(res_c) && carry_out == $past(cry_c)));
    end else begin : g_comb
      assign result    = res_c;
      assign carry_out = cry_c;
    end
  endgenerate

  assert_zero_shift_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (n == '0) |-> (res_c == data_in && cry_c == '0));

  assert_rebuild_data_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (n != '0) |-> (((res_c << n) | (cry_c >> back)) == data_in));

  assert_carry_low_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (n != '0) |-> ((cry_c << n) == '0));

  assert_top_from_carry_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (n != '0) |-> ((res_c >> back) == (carry_in >> back)));
endmodule

// File: tb/sim_limb_rshift_carry.sv
`timescale 1ns/1ps
module sim_limb_rshift_carry;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [63:0] d, c, a;
  logic [63:0] r0, co0, r1, co1;
  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  limb_rshift_carry #(.W(64), .OUT_REG(1'b0)) u0 (
    .clk(clk), .rst_n(rst_n), .data_in(d), .carry_in(c), .amount(a),
    .result(r0), .carry_out(co0));

  limb_rshift_carry #(.W(64), .OUT_REG(1'b1)) u1 (
    .clk(clk), .rst_n(rst_n), .data_in(d), .carry_in(c), .amount(a),
    .result(r1), .carry_out(co1));

  function automatic void model(input logic [63:0] dd, input logic [63:0] cc,
                                input int n, output logic [63:0] rr,
                                output logic [63:0] oo);
    logic [127:0] f;
    f = {dd, 64'd0} >> n;
    rr = f[127:64];
    oo = f[63:0];
    for (int i = 0; i < 64; i++)
      if (i >= 64 - n) rr[i] = cc[i];
  endfunction

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  function automatic logic [63:0] rnd64();
    return {$urandom(), $urandom()};
  endfunction

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin : main
    logic [63:0] er, eo;
    logic [255:0] big, shifted;
    logic [63:0] limb_res [4];
    logic [63:0] cy;
    d = 64'hFEDC_BA98_7654_3210; c = 64'hFFFF_FFFF_FFFF_FFFF; a = 64'd5;
    repeat (3) @(posedge clk);
    #1;
    chk("R7 reset result", r1, 64'd0);
    chk("R7 reset carry", co1, 64'd0);
    @(negedge clk) rst_n = 1'b1;

    for (int n = 0; n < 64; n++) begin
      for (int p = 0; p < 6; p++) begin
        case (p)
          0: begin d = 64'hFFFF_FFFF_FFFF_FFFF; c = 64'd0; end
          1: begin d = 64'd0; c = 64'hFFFF_FFFF_FFFF_FFFF; end
          2: begin d = 64'h8000_0000_0000_0001; c = 64'h5555_5555_5555_5555; end
          default: begin d = rnd64(); c = rnd64(); end
        endcase
        a = {rnd64() >> 6, 6'(n)};
        if (p == 0) a = 64'(n);
        model(d, c, n, er, eo);
        #1;
        chk((n == 0) ? "R5 result" : "R2 R3 result", r0, er);
        chk((n == 0) ? "R5 carry" : "R4 carry", co0, eo);
        @(posedge clk);
        #1;
        chk("R7 R1 registered result", r1, er);
        chk("R7 R1 registered carry", co1, eo);
        @(negedge clk);
      end
    end

    for (int n = 0; n < 64; n += 3) begin
      big = {rnd64(), rnd64(), rnd64(), rnd64()};
      shifted = big >> n;
      cy = 64'd0;
      for (int k = 3; k >= 0; k--) begin
        d = big[64*k +: 64];
        c = cy;
        a = {rnd64() >> 6, 6'(n)};
        #1;
        limb_res[k] = r0;
        cy = co0;
        @(negedge clk);
      end
      for (int k = 0; k < 4; k++)
        chk("R6 chained limb", limb_res[k], shifted[64*k +: 64]);
    end

    d = rnd64(); c = rnd64();
    a = 64'hFFFF_FFFF_FFFF_FFC0;
    #1;
    chk("R1 high bits ignored result", r0, d);
    chk("R1 high bits ignored carry", co0, 64'd0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule